// File: doc/BRIEF.md
# General-Purpose Parallel Bus Master

This block is a synchronous master for a simple external parallel bus. An internal client presents one request at a time (direction, address, write data) with a valid/ready handshake, and the block turns each request into a short run of bus cycles on the pins. These cycles put out an address, drive or release a split bidirectional data bus, and pulse read and write strobes. Read results return to the client as a one-cycle valid pulse with the captured data.

Three configuration inputs shape each transaction. The first decides whether the strobes are driven at all. When it is off, the peripheral is expected to know the direction by other means. The second selects single-cycle or split two-cycle writes. The third sets how many address bits reach the pins. All three are sampled when a request is accepted and hold for that whole transaction. Reads always use two bus cycles: the strobe goes out first, and the data is captured later, so the peripheral has setup time even when no address is used. Selecting split writes forces the strobes on, whatever the strobe-enable input says.

Top module: `gpBusMaster`

## Requirements
- R1: Out of reset and between transactions, reqReady is 1 and busRd, busWr and busOe are 0, and busAddr and busDout are all zeros.
- R2: A request is accepted in a cycle where reqValid and reqReady are both 1. reqReady is 0 from the following cycle until the last bus cycle of that transaction has ended.
- R3: A read takes two bus cycles, starting the cycle after acceptance. The address is driven in both cycles and busOe is 0 in both. busRd is 1 in the first cycle only, and only when strobes are in effect. busDin is sampled at the clock edge that ends the second cycle.
- R4: The cycle after a read's second bus cycle, rspValid is 1 for exactly one cycle and rspData equals the value sampled from busDin. rspValid is 0 in every other cycle.
- R5: With cfgWrTwoCycle = 0, a write takes one bus cycle. In that cycle the address and write data are driven, busOe is 1, and busWr is 1 if cfgStrobeEn is 1.
- R6: With cfgWrTwoCycle = 1, a write takes two bus cycles. In the first, the address is driven with busWr = 1, busOe = 0 and busDout = 0. In the second, the address and write data are driven with busWr = 0 and busOe = 1.
- R7: When a transaction is accepted with cfgStrobeEn = 0 and cfgWrTwoCycle = 0, neither busRd nor busWr is asserted during it.
- R8: When a transaction is accepted with cfgWrTwoCycle = 1, strobes are in effect regardless of cfgStrobeEn. A read then asserts busRd in its first cycle, and a write asserts busWr in its first cycle.
- R9: cfgAddrSize picks the address bits driven. 2'b00 means no address, so busAddr is 0. 2'b01 drives reqAddr[3:0], 2'b10 drives reqAddr[11:0] and 2'b11 drives reqAddr[19:0]. All other busAddr bits are 0.
- R10: busRd and busWr are never 1 in the same cycle, and busOe is never 1 while busRd is 1.
- R11: The configuration inputs are sampled only at acceptance. Changing them during a transaction does not alter its remaining bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data |
| reqReady | output | 1 | Block can accept a request this cycle |
| rspValid | output | 1 | One-cycle pulse with read data |
| rspData | output | DATA_W | Captured read data |
| cfgStrobeEn | input | 1 | Drive the read/write strobes |
| cfgWrTwoCycle | input | 1 | Split writes into address and data cycles |
| cfgAddrSize | input | 2 | Address width code |
| busAddr | output | ADDR_W | Address pins |
| busDout | output | DATA_W | Data bus outgoing value |
| busDin | input | DATA_W | Data bus incoming value |
| busOe | output | 1 | Data bus output enable |
| busRd | output | 1 | Read strobe, active high |
| busWr | output | 1 | Write strobe, active high |

## Verification
The assertions take for granted that the request and configuration inputs carry known values whenever reqValid is high. They also assume busDin is settled before the clock edge that closes the second cycle of a read, because the capture property compares rspData with the sampled value. The stimulus changes every input only at the falling clock edge, half a cycle clear of any sampling edge. It also moves the configuration inputs at random during transactions, so the rule of sampling only at acceptance is exercised without breaking these assumptions.

// File: rtl/gpBusPkg.sv
package gpBusPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ADDR,
    ST_RD_CAP,
    ST_WR_ONE,
    ST_WR_ADDR,
    ST_WR_DATA
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic addrOn;
    logic dataOn;
    logic capture;
  } busCtl_t;

  localparam logic [1:0] ASZ_NONE = 2'b00;
  localparam logic [1:0] ASZ_4    = 2'b01;
  localparam logic [1:0] ASZ_12   = 2'b10;
  localparam logic [1:0] ASZ_20   = 2'b11;

endpackage

// File: rtl/gpBusCtrl.sv
module gpBusCtrl
  import gpBusPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    cfgStrobeEn,
  input  logic    cfgWrTwoCycle,
  output logic    reqReady,
  output logic    busRd,
  output logic    busWr,
  output busCtl_t ctl
);

  busState_t state, nextState;
  logic      strobeOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      strobeOn <= 1'b0;
    end else begin
      state <= nextState;
      if (ctl.load) strobeOn <= cfgStrobeEn | cfgWrTwoCycle;
    end
  end

  always_comb begin
    nextState = state;
    reqReady  = 1'b0;
    busRd     = 1'b0;
    busWr     = 1'b0;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.load = 1'b1;
          if (!reqWrite)         nextState = ST_RD_ADDR;
          else if (cfgWrTwoCycle) nextState = ST_WR_ADDR;
          else                    nextState = ST_WR_ONE;
        end
      end
      ST_RD_ADDR: begin
        busRd      = strobeOn;
        ctl.addrOn = 1'b1;
        nextState  = ST_RD_CAP;
      end
      ST_RD_CAP: begin
        ctl.addrOn  = 1'b1;
        ctl.capture = 1'b1;
        nextState   = ST_IDLE;
      end
      ST_WR_ONE: begin
        busWr      = strobeOn;
        ctl.addrOn = 1'b1;
        ctl.dataOn = 1'b1;
        nextState  = ST_IDLE;
      end
      ST_WR_ADDR: begin
        busWr      = strobeOn;
        ctl.addrOn = 1'b1;
        nextState  = ST_WR_DATA;
      end
      ST_WR_DATA: begin
        ctl.addrOn = 1'b1;
        ctl.dataOn = 1'b1;
        nextState  = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R2
  AST_READ_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    busRd |=> (!busRd && ctl.capture)); // R3
  AST_SPLIT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WR_ADDR) |=> (ctl.dataOn && !busWr)); // R6
  AST_STROBES_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !cfgStrobeEn && !cfgWrTwoCycle) |=> (!busRd && !busWr)); // R7
  AST_FORCED_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && cfgWrTwoCycle) |=> (busRd || busWr)); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr) && !(busRd && ctl.dataOn)); // R10

endmodule

// File: rtl/gpBusDatapath.sv
module gpBusDatapath
  import gpBusPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        cfgAddrSize,
  input  logic [DATA_W-1:0] busDin,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  output logic              busOe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  localparam int NARROW_BITS = 4;
  localparam int MID_BITS    = 12;
  localparam int WIDE_BITS   = 20;

  logic [ADDR_W-1:0] keepMask;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
    assign keepMask[i] = ((cfgAddrSize == ASZ_4)  && (i < NARROW_BITS)) ||
                         ((cfgAddrSize == ASZ_12) && (i < MID_BITS))    ||
                         ((cfgAddrSize == ASZ_20) && (i < WIDE_BITS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      dataReg  <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (ctl.load) begin
        addrReg <= reqAddr & keepMask;
        dataReg <= reqWdata;
      end
      rspValid <= ctl.capture;
      if (ctl.capture) rspData <= busDin;
    end
  end

  assign busAddr = ctl.addrOn ? addrReg : '0;
  assign busDout = ctl.dataOn ? dataReg : '0;
  assign busOe   = ctl.dataOn;

  AST_RSP_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (rspValid && rspData == $past(busDin))); // R4
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R4
  AST_NO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && cfgAddrSize == ASZ_NONE) |=> (busAddr == '0)); // R9

endmodule

// File: rtl/gpBusMaster.sv
module gpBusMaster
  import gpBusPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  input  logic              cfgStrobeEn,
  input  logic              cfgWrTwoCycle,
  input  logic [1:0]        cfgAddrSize,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  input  logic [DATA_W-1:0] busDin,
  output logic              busOe,
  output logic              busRd,
  output logic              busWr
);

  busCtl_t ctl;

  gpBusCtrl uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .reqWrite      (reqWrite),
    .cfgStrobeEn   (cfgStrobeEn),
    .cfgWrTwoCycle (cfgWrTwoCycle),
    .reqReady      (reqReady),
    .busRd         (busRd),
    .busWr         (busWr),
    .ctl           (ctl)
  );

  gpBusDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .cfgAddrSize (cfgAddrSize),
    .busDin      (busDin),
    .busAddr     (busAddr),
    .busDout     (busDout),
    .busOe       (busOe),
    .rspValid    (rspValid),
    .rspData     (rspData)
  );

  AST_OE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> !busRd); // R10

endmodule

// File: tb/gpBusMaster_test.sv
`timescale 1ns/1ps
module gpBusMaster_test;

  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          reqReady, rspValid;
  logic [DW-1:0] rspData;
  logic          cfgStrobeEn = 1'b1, cfgWrTwoCycle = 1'b0;
  logic [1:0]    cfgAddrSize = 2'b11;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busDout;
  logic [DW-1:0] busDin = '0;
  logic          busOe, busRd, busWr;

  int testsRun = 0;
  int testsFailed = 0;

  always #5 clk = ~clk;

  gpBusMaster #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspValid(rspValid), .rspData(rspData), .cfgStrobeEn(cfgStrobeEn),
    .cfgWrTwoCycle(cfgWrTwoCycle), .cfgAddrSize(cfgAddrSize),
    .busAddr(busAddr), .busDout(busDout), .busDin(busDin),
    .busOe(busOe), .busRd(busRd), .busWr(busWr)
  );

  typedef struct {
    bit            ready, rd, wr, oe, rspV, isCap, busy;
    logic [AW-1:0] addr;
    logic [DW-1:0] dout;
    string         tag;
    bit            sEn, two;
    bit [1:0]      sz;
  } cycleExp_t;

  cycleExp_t     expQ[$];
  bit            modelReady = 1'b1;
  logic [DW-1:0] lastCapture = '0;

  function automatic logic [AW-1:0] visibleAddr(logic [AW-1:0] a, bit [1:0] sz);
    case (sz)
      2'b00:   return '0;
      2'b01:   return a & 20'h0000F;
      2'b10:   return a & 20'h00FFF;
      default: return a & 20'hFFFFF;
    endcase
  endfunction

  function automatic cycleExp_t idleExp();
    cycleExp_t e;
    e.ready = 1; e.rd = 0; e.wr = 0; e.oe = 0; e.rspV = 0; e.isCap = 0; e.busy = 0;
    e.addr = '0; e.dout = '0; e.tag = "R1"; e.sEn = 0; e.two = 0; e.sz = 0;
    return e;
  endfunction

  // reference model: on acceptance, queue the expected cycles of the transaction
  always @(posedge clk) begin
    if (rstN && reqValid && modelReady) begin
      cycleExp_t e;
      bit strobe;
      logic [AW-1:0] a;
      strobe = cfgStrobeEn | cfgWrTwoCycle;
      a = visibleAddr(reqAddr, cfgAddrSize);
      e = idleExp();
      e.ready = 0; e.busy = 1; e.addr = a;
      e.sEn = cfgStrobeEn; e.two = cfgWrTwoCycle; e.sz = cfgAddrSize;
      if (!reqWrite) begin
        e.tag = "R3"; e.rd = strobe; expQ.push_back(e);
        e.rd = 0; e.isCap = 1; expQ.push_back(e);
        e = idleExp(); e.rspV = 1; e.tag = "R4"; expQ.push_back(e);
      end else if (!cfgWrTwoCycle) begin
        e.tag = "R5"; e.wr = strobe; e.oe = 1; e.dout = reqWdata; expQ.push_back(e);
      end else begin
        e.tag = "R6"; e.wr = 1; expQ.push_back(e);
        e.wr = 0; e.oe = 1; e.dout = reqWdata; expQ.push_back(e);
      end
    end
  end

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareCycle();
    cycleExp_t e;
    string sTag, fTag;
    bit moved;
    e = (expQ.size() > 0) ? expQ.pop_front() : idleExp();
    moved = e.busy && (cfgStrobeEn != e.sEn || cfgWrTwoCycle != e.two || cfgAddrSize != e.sz);
    fTag = moved ? "R11" : e.tag;
    if (moved)                   sTag = "R11";
    else if (e.busy && !e.sEn && !e.two) sTag = "R7";
    else if (e.busy && e.two)    sTag = "R8";
    else                         sTag = e.tag;
    check(reqReady == e.ready, "R2", "reqReady", reqReady, e.ready);
    check(busRd == e.rd, sTag, "busRd", busRd, e.rd);
    check(busWr == e.wr, sTag, "busWr", busWr, e.wr);
    check(busOe == e.oe, fTag, "busOe", busOe, e.oe);
    check(busAddr == e.addr, moved ? "R11" : (e.busy ? "R9" : "R1"), "busAddr", busAddr, e.addr);
    check(busDout == e.dout, fTag, "busDout", busDout, e.dout);
    check(rspValid == e.rspV, "R4", "rspValid", rspValid, e.rspV);
    if (e.rspV) check(rspData == lastCapture, "R4", "rspData", rspData, lastCapture);
    check(!(busRd && busWr) && !(busRd && busOe), "R10", "rd/wr/oe overlap",
          {busRd, busWr, busOe}, 0);
    modelReady = e.ready;
    if (e.isCap) e.busy = 1;
    // drive the next inputs
    busDin = DW'($urandom);
    if (e.isCap) lastCapture = busDin;
    reqValid = ($urandom % 10) < 6;
    reqWrite = $urandom % 2;
    reqAddr  = AW'($urandom);
    reqWdata = DW'($urandom);
    if (($urandom % 5) == 0) begin
      cfgStrobeEn   = $urandom % 2;
      cfgWrTwoCycle = ($urandom % 3) == 0;
      cfgAddrSize   = 2'($urandom);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady == 1 && !busRd && !busWr && !busOe && busAddr == 0 && busDout == 0,
          "R1", "reset outputs", {reqReady, busRd, busWr, busOe}, 4'b1000);
    rstN = 1'b1;
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      compareCycle();
    end
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(200000 * 10);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule